// File: doc/BRIEF.md
# Refresh and DMA Bus Arbiter

This block decides who uses the expansion bus next: a periodic memory refresh, or a DMA transfer that has asked for bus hold. A timer tick marks a refresh as owed. When the bus is idle and no DMA request is waiting, the block asks the DRAM side for permission over a request/acknowledge link. Once the acknowledge comes back, it runs a refresh cycle on the bus. That cycle drives the current row number onto the low address lines and pulls both memory-read strobes low for a fixed number of clocks. A DMA grant that becomes possible during this sequence is held back until the sequence ends.

An external bus master can also start a refresh by pulling its refresh line low. In that case there is no arbitration: the row address and both strobes appear at once, and a local-refresh output tells the DRAM side to refresh its own memory. Two configuration inputs shape the behaviour. One lets timer ticks count as refresh requests. The other lets the bus refresh cycle actually be driven; with it clear, the handshake still runs but the cycle ends as soon as the acknowledge arrives. When no refresh is running, the block passes the ordinary memory-read strobe through and decodes the low-memory strobe from the top address nibble.

Top module: `rfsh_dma_arb`

## Requirements
- R1: While reset is held: link_req=0, dma_gnt=0, memr_n=1, smemr_n=1, sa_oe=0, loc_rfsh_n=1, sa_out=0. After reset no refresh is owed and the row counter is 0.
- R2: A tmr_tick marks a refresh as owed only when cfg_tick_en=1. A tick with cfg_tick_en=0 never leads to link_req.
- R3: If a refresh is owed, the bus is idle and dma_req=0, link_req rises on the second clock edge after the tick. It stays high until link_ack is sampled high.
- R4: With cfg_isa_en=1, the cycle after link_ack is sampled starts the hidden refresh strobe. For exactly STRB_CLKS clocks (default 4), memr_n=0, smemr_n=0, sa_oe=1 and sa_out=row, whatever the value of addr_hi.
- R5: With cfg_isa_en=0, link_ack ends the sequence at once. In the next cycle link_req=0, sa_oe=0 and no strobe is driven. The sequence still counts as complete.
- R6: During a hidden refresh, dma_gnt stays 0 even when dma_req=1 and hold_ack=1. It goes to 1 on the second cycle after the last strobe cycle.
- R7: If dma_req and the owed refresh appear in the same clock while idle, DMA wins and dma_gnt=hold_ack. link_req rises on the second cycle after dma_req falls.
- R8: While ext_rfsh_n=0 with the bus idle or granted to DMA, the outputs change in the same cycle without any link handshake: memr_n=0, smemr_n=0, sa_oe=1, sa_out=row and loc_rfsh_n=0. An owed refresh does not touch the bus.
- R9: Outside refresh, memr_n follows bus_memr_n. smemr_n=0 only when bus_memr_n=0 and addr_hi==0.
- R10: The 8-bit row counter advances by one after each completed sequence: hidden, ISA-disabled, or master (on the edge after ext_rfsh_n returns high). It wraps from 255 to 0.
- R11: Ticks that arrive while a refresh is already owed are not queued, so one refresh sequence follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tick_en | input | 1 | Lets timer ticks request refresh |
| cfg_isa_en | input | 1 | Lets the bus refresh cycle be driven |
| tmr_tick | input | 1 | Periodic refresh tick from the timer |
| dma_req | input | 1 | DMA hold request |
| hold_ack | input | 1 | Host hold acknowledge |
| dma_gnt | output | 1 | Grant to the DMA controller |
| link_req | output | 1 | Refresh request toward the DRAM side |
| link_ack | input | 1 | Refresh acknowledge from the DRAM side |
| ext_rfsh_n | input | 1 | Master-driven refresh, active low |
| loc_rfsh_n | output | 1 | Local refresh indication, active low |
| bus_memr_n | input | 1 | Ordinary memory-read strobe, active low |
| addr_hi | input | HI_W | Address bits 23:20 |
| memr_n | output | 1 | Memory-read strobe, active low |
| smemr_n | output | 1 | Low-memory read strobe, active low |
| sa_out | output | ROW_W | Refresh row on the low address lines |
| sa_oe | output | 1 | Enable for sa_out |

## Verification
Two collisions get targeted stimulus. The first is a DMA request and a refresh tick in the same clock. The bench raises dma_req and tmr_tick on one edge and checks that dma_gnt follows hold_ack while link_req stays low, and that link_req rises exactly two cycles after the request is dropped. The second is a DMA request and hold acknowledge that arrive in the middle of a hidden refresh. Every strobe cycle is checked for a low grant, and the grant must appear on the second cycle after the strobe ends. Random address and strobe patterns check the pass-through decode against a bench model.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DMA  = 2'd1,
      ST_LREQ = 2'd2,
      ST_STRB = 2'd3
   } rfa_state_e;
endpackage

// File: rtl/rfa_pend.sv
module rfa_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic tick_en,
   input  logic done,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)               pend <= 1'b0;
      else if (done)            pend <= 1'b0;
      else if (tick && tick_en) pend <= 1'b1;
   end

   // R2
   pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(tick && tick_en));
endmodule

// File: rtl/rfa_row.sv
module rfa_row #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   if (ROW_W < 1) begin : g_bad_w
      $error("rfa_row: ROW_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   row <= '0;
      else if (adv) row <= row + 1'b1;
   end

   // R10
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row) |-> (row == $past(row) + ROW_W'(1)));
endmodule

// File: rtl/rfa_ctl.sv
module rfa_ctl
   import rfa_pkg::*;
#(
   parameter int STRB_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic tick_en,
   input  logic isa_en,
   input  logic dma_req,
   input  logic hold_ack,
   input  logic link_ack,
   input  logic mst_busy,
   output logic link_req,
   output logic hid_strb,
   output logic dma_gnt,
   output logic bus_free,
   output logic done
);
   localparam int CNT_W = (STRB_CLKS > 1) ? $clog2(STRB_CLKS) : 1;

   if (STRB_CLKS < 1) begin : g_bad_len
      $error("rfa_ctl: STRB_CLKS must be at least 1");
   end

   rfa_state_e st, st_nx;
   logic       last;

   if (STRB_CLKS == 1) begin : g_single
      assign last = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (st == ST_STRB)  cnt <= cnt + 1'b1;
         else                     cnt <= '0;
      end
      assign last = (cnt == CNT_W'(STRB_CLKS - 1));

      // R4
      strb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(hid_strb) |-> ($past(cnt) == CNT_W'(STRB_CLKS - 1)));
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: begin
            if (dma_req)                             st_nx = ST_DMA;
            else if (pend && tick_en && !mst_busy)   st_nx = ST_LREQ;
         end
         ST_DMA:  if (!dma_req) st_nx = ST_IDLE;
         ST_LREQ: if (link_ack) st_nx = isa_en ? ST_STRB : ST_IDLE;
         ST_STRB: if (last)     st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign link_req = (st == ST_LREQ);
   assign hid_strb = (st == ST_STRB);
   assign dma_gnt  = (st == ST_DMA) && hold_ack;
   assign bus_free = (st == ST_IDLE) || (st == ST_DMA);
   assign done     = ((st == ST_LREQ) && link_ack && !isa_en) ||
                     ((st == ST_STRB) && last);

   // R3
   link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_req) |-> $past(link_ack));

   // R6
   gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt |-> (!hid_strb && !link_req));
endmodule

// File: rtl/rfsh_dma_arb.sv
module rfsh_dma_arb #(
   parameter int ROW_W     = 8,
   parameter int STRB_CLKS = 4,
   parameter int HI_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tick_en,
   input  logic             cfg_isa_en,
   input  logic             tmr_tick,
   input  logic             dma_req,
   input  logic             hold_ack,
   output logic             dma_gnt,
   output logic             link_req,
   input  logic             link_ack,
   input  logic             ext_rfsh_n,
   output logic             loc_rfsh_n,
   input  logic             bus_memr_n,
   input  logic [HI_W-1:0]  addr_hi,
   output logic             memr_n,
   output logic             smemr_n,
   output logic [ROW_W-1:0] sa_out,
   output logic             sa_oe
);
   if (HI_W < 1) begin : g_bad_hi
      $error("rfsh_dma_arb: HI_W must be at least 1");
   end

   logic             pend, done, hid_strb, bus_free;
   logic             mst_act, mst_q, rfsh, adv;
   logic [ROW_W-1:0] row;

   assign mst_act = !ext_rfsh_n && bus_free;

   always_ff @(posedge clk) begin
      if (!rst_n) mst_q <= 1'b0;
      else        mst_q <= mst_act;
   end

   assign adv = done || (mst_q && !mst_act);

   rfa_pend u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tmr_tick),
      .tick_en (cfg_tick_en),
      .done    (done),
      .pend    (pend)
   );

   rfa_row #(.ROW_W(ROW_W)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .row   (row)
   );

   rfa_ctl #(.STRB_CLKS(STRB_CLKS)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .tick_en  (cfg_tick_en),
      .isa_en   (cfg_isa_en),
      .dma_req  (dma_req),
      .hold_ack (hold_ack),
      .link_ack (link_ack),
      .mst_busy (!ext_rfsh_n),
      .link_req (link_req),
      .hid_strb (hid_strb),
      .dma_gnt  (dma_gnt),
      .bus_free (bus_free),
      .done     (done)
   );

   assign rfsh       = hid_strb || mst_act;
   assign sa_oe      = rfsh;
   assign sa_out     = rfsh ? row : '0;
   assign memr_n     = rfsh ? 1'b0 : bus_memr_n;
   assign smemr_n    = rfsh ? 1'b0 : (bus_memr_n || (|addr_hi));
   assign loc_rfsh_n = !mst_act;

   // R9
   smem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smemr_n && !sa_oe) |-> ((addr_hi == '0) && !memr_n));

   // R8
   mst_lout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_rfsh_n |-> (!memr_n && !smemr_n && sa_oe && !link_req));

   // R4
   rfsh_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sa_oe |-> (!memr_n && !smemr_n));
endmodule

// File: tb/test_rfsh_dma_arb.sv
`timescale 1ns/1ps
module test_rfsh_dma_arb;
   localparam int ROW_W = 8;
   localparam int STRB_CLKS = 4;
   localparam int HI_W = 4;

   logic clk = 1'b0;
   logic rst_n, cfg_tick_en, cfg_isa_en, tmr_tick, dma_req, hold_ack;
   logic link_ack, ext_rfsh_n, bus_memr_n;
   logic [HI_W-1:0] addr_hi;
   logic dma_gnt, link_req, loc_rfsh_n, memr_n, smemr_n, sa_oe;
   logic [ROW_W-1:0] sa_out;

   int n_chk = 0;
   int n_fail = 0;
   int exp_row = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   rfsh_dma_arb #(.ROW_W(ROW_W), .STRB_CLKS(STRB_CLKS), .HI_W(HI_W)) i_rfsh_dma_arb (
      .clk(clk), .rst_n(rst_n), .cfg_tick_en(cfg_tick_en), .cfg_isa_en(cfg_isa_en),
      .tmr_tick(tmr_tick), .dma_req(dma_req), .hold_ack(hold_ack), .dma_gnt(dma_gnt),
      .link_req(link_req), .link_ack(link_ack), .ext_rfsh_n(ext_rfsh_n),
      .loc_rfsh_n(loc_rfsh_n), .bus_memr_n(bus_memr_n), .addr_hi(addr_hi),
      .memr_n(memr_n), .smemr_n(smemr_n), .sa_out(sa_out), .sa_oe(sa_oe)
   );

   function automatic bit exp_smem(input bit rd_n, input logic [HI_W-1:0] hi);
      return rd_n || (hi != '0);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk);
      #1;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // link_ack and complete the sequence; checks strobe length and row
   task automatic finish_seq(input bit isa);
      int cnt;
      link_ack = 1'b1;
      nx();
      link_ack = 1'b0;
      if (isa) begin
         cnt = 0;
         for (int i = 0; i < 20; i++) begin
            if (!sa_oe) break;
            cnt++;
            chk(sa_out == ROW_W'(exp_row), "R4 row", int'(sa_out), exp_row);
            chk(!memr_n && !smemr_n, "R4 strobes", int'({memr_n, smemr_n}), 0);
            chk(!dma_gnt, "R6 gnt held", int'(dma_gnt), 0);
            nx();
         end
         chk(cnt == STRB_CLKS, "R4 length", cnt, STRB_CLKS);
      end else begin
         chk(!link_req && !sa_oe && memr_n, "R5 no cycle",
             int'({link_req, sa_oe, memr_n}), 1);
      end
      exp_row = (exp_row + 1) % 256;
   endtask

   task automatic start_hidden(input bit dbl);
      tmr_tick = 1'b1;
      nx();
      if (dbl) nx();
      tmr_tick = 1'b0;
      if (!dbl) begin
         chk(!link_req, "R3 not yet", int'(link_req), 0);
         nx();
      end
      chk(link_req, "R3 link_req", int'(link_req), 1);
      for (int i = 0; i < 3; i++) begin
         nx();
         chk(link_req, "R3 hold", int'(link_req), 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         report();
      end
   end

   initial begin
      int unsigned sd;
      bit hit;
      sd = $urandom(32'd1995);
      rst_n = 1'b0; cfg_tick_en = 1'b0; cfg_isa_en = 1'b1; tmr_tick = 1'b0;
      dma_req = 1'b0; hold_ack = 1'b0; link_ack = 1'b0; ext_rfsh_n = 1'b1;
      bus_memr_n = 1'b1; addr_hi = '0;
      repeat (3) nx();
      // R1
      chk(!link_req && !dma_gnt && memr_n && smemr_n && !sa_oe && loc_rfsh_n && sa_out == 0,
          "R1 reset", int'({link_req, dma_gnt, memr_n, smemr_n, sa_oe, loc_rfsh_n}), 6'b001101);
      rst_n = 1'b1;
      nx();

      // R2: ticks gated off
      tmr_tick = 1'b1; nx(); tmr_tick = 1'b0;
      hit = 1'b0;
      for (int i = 0; i < 8; i++) begin nx(); hit |= link_req; end
      chk(!hit, "R2 gated tick", int'(hit), 0);
      cfg_tick_en = 1'b1;

      // R3 R4 R10: two hidden refreshes, upper address nonzero
      addr_hi = 4'hA;
      start_hidden(1'b0); finish_seq(1'b1);
      start_hidden(1'b0); finish_seq(1'b1);

      // R11: two ticks, one sequence
      start_hidden(1'b1); finish_seq(1'b1);
      hit = 1'b0;
      for (int i = 0; i < 8; i++) begin nx(); hit |= link_req; end
      chk(!hit, "R11 not queued", int'(hit), 0);

      // R5: ISA disabled, then R10 check through next row
      cfg_isa_en = 1'b0;
      start_hidden(1'b0); finish_seq(1'b0);
      cfg_isa_en = 1'b1;
      start_hidden(1'b0); finish_seq(1'b1);

      // R6: DMA arrives during hidden refresh
      start_hidden(1'b0);
      dma_req = 1'b1; hold_ack = 1'b1;
      nx();
      chk(!dma_gnt, "R6 gnt in lreq", int'(dma_gnt), 0);
      finish_seq(1'b1);
      chk(!dma_gnt, "R6 gnt idle gap", int'(dma_gnt), 0);
      nx();
      chk(dma_gnt, "R6 gnt after", int'(dma_gnt), 1);
      dma_req = 1'b0; hold_ack = 1'b0;
      nx(); nx();

      // R7: DMA and tick together
      tmr_tick = 1'b1; dma_req = 1'b1; hold_ack = 1'b1;
      nx();
      tmr_tick = 1'b0;
      chk(dma_gnt && !link_req, "R7 dma wins", int'({dma_gnt, link_req}), 2);
      hold_ack = 1'b0; #1;
      chk(!dma_gnt, "R7 gnt follows ack", int'(dma_gnt), 0);
      hold_ack = 1'b1;
      hit = 1'b0;
      for (int i = 0; i < 4; i++) begin nx(); hit |= link_req; end
      chk(!hit, "R7 refresh waits", int'(hit), 0);
      dma_req = 1'b0; hold_ack = 1'b0;
      nx();
      chk(!link_req && !dma_gnt, "R7 idle", int'({link_req, dma_gnt}), 0);
      nx();
      chk(link_req, "R7 refresh after", int'(link_req), 1);
      finish_seq(1'b1);

      // R8: master refresh
      addr_hi = 4'h3;
      ext_rfsh_n = 1'b0; #1;
      for (int i = 0; i < 3; i++) begin
         chk(!memr_n && !smemr_n && sa_oe && !loc_rfsh_n && !link_req,
             "R8 master", int'({memr_n, smemr_n, sa_oe, loc_rfsh_n, link_req}), 5'b00100);
         chk(sa_out == ROW_W'(exp_row), "R8 row", int'(sa_out), exp_row);
         nx();
      end
      ext_rfsh_n = 1'b1; #1;
      chk(loc_rfsh_n && !sa_oe, "R8 release", int'({loc_rfsh_n, sa_oe}), 2);
      nx();
      exp_row = (exp_row + 1) % 256;

      // R10: wrap through 256 master cycles
      for (int k = 0; k < 256; k++) begin
         ext_rfsh_n = 1'b0; nx(); ext_rfsh_n = 1'b1; nx();
      end
      ext_rfsh_n = 1'b0; #1;
      chk(sa_out == ROW_W'(exp_row), "R10 wrap", int'(sa_out), exp_row);
      ext_rfsh_n = 1'b1; nx();
      exp_row = (exp_row + 1) % 256;

      // R9: random pass-through decode
      for (int k = 0; k < 200; k++) begin
         bus_memr_n = 1'($urandom);
         addr_hi = ($urandom % 3 == 0) ? '0 : HI_W'($urandom);
         #1;
         chk(memr_n == bus_memr_n, "R9 memr", int'(memr_n), int'(bus_memr_n));
         chk(smemr_n == exp_smem(bus_memr_n, addr_hi), "R9 smemr",
             int'(smemr_n), int'(exp_smem(bus_memr_n, addr_hi)));
         nx();
      end
      bus_memr_n = 1'b1;

      done_flag = 1'b1;
      report();
   end
endmodule